// File: doc/BRIEF.md
# Register/Immediate Integer Execute Stage

This block is the combinational arithmetic and logic stage of a simple 32-bit integer pipeline. It takes the first source register value, the second source register value, a 16-bit immediate field, the primary opcode and the function field. It returns one result word in the same cycle. It holds no state, so the house-style state register becomes a decoded operation enum. A decoder maps the opcode and function field to that enum. The same decoder also picks the second operand (register or immediate) and the extension mode.

Immediates are widened in one of three ways, depending on the instruction class:
- Arithmetic immediates are sign-extended.
- Logical immediates are zero-extended.
- Load-upper-immediate places the field in the high half of the result and fills the low half with zeros.

Results wrap and raise no exceptions. An encoding outside the supported set yields zero.

The decoded operations (the "states" of the decode step) are `OP_ADD`, `OP_SUB`, `OP_AND`, `OP_OR`, `OP_XOR`, `OP_NOR`, `OP_SLT`, `OP_PASS_B` (used by load-upper) and `OP_NONE`. Each input pattern selects exactly one of them. There is no sequencing between them.

Top module: `alu_execute`

## Requirements
- R1: With opcode 0 and function 32, result = rs_val + rt_val modulo 2^32, with no exception on carry out.
- R2: With opcode 0 and function 34, result = rs_val - rt_val modulo 2^32.
- R3: With opcode 0, functions 36, 37 and 38 give the bitwise AND, OR and XOR of rs_val and rt_val, in that order.
- R4: With opcode 0 and function 39, result = ~(rs_val | rt_val); two zero operands give 0xFFFFFFFF.
- R5: With opcode 0 and function 42, result is 1 when rs_val < rt_val as signed two's-complement numbers, and 0 otherwise.
- R6: Opcode 8 adds rs_val to the immediate sign-extended from bit 15, modulo 2^32.
- R7: Opcodes 12, 13 and 14 give AND, OR and XOR of rs_val with the immediate zero-extended to 32 bits.
- R8: Opcode 15 gives {imm, 16'h0000}; rs_val and rt_val have no effect.
- R9: Immediate-form instructions (opcodes 8, 12, 13, 14, 15) ignore rt_val; register-form instructions (opcode 0) ignore imm.
- R10: Any other opcode, or opcode 0 with a function code not listed above, gives a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 6 | Primary opcode |
| func_code | input | 6 | Function field for register-form operations |
| rs_val | input | 32 | First source operand |
| rt_val | input | 32 | Second source register operand |
| imm | input | 16 | Immediate field |
| result | output | 32 | Computed result word |

## Verification
The bench builds the block with the default 32-bit data width and 16-bit immediate width. Those widths make two boundaries reachable directly:
- Bit 15 of the immediate, where sign extension and zero extension disagree.
- The 2^32 wrap point of the adder and subtractor.

They also make the signed versus unsigned split reachable for set-less-than, through operands whose top bit differs. Every supported code is driven, along with unlisted function and opcode values, and with the ignored operand changed to show it has no effect.

// File: rtl/alu_ex_pkg.sv
package alu_ex_pkg;
    localparam int OPC_W = 6;
    localparam int FN_W  = 6;

    localparam logic [OPC_W-1:0] OPC_REG  = 6'd0;
    localparam logic [OPC_W-1:0] OPC_ADDI = 6'd8;
    localparam logic [OPC_W-1:0] OPC_ANDI = 6'd12;
    localparam logic [OPC_W-1:0] OPC_ORI  = 6'd13;
    localparam logic [OPC_W-1:0] OPC_XORI = 6'd14;
    localparam logic [OPC_W-1:0] OPC_LUI  = 6'd15;

    localparam logic [FN_W-1:0] FN_ADD = 6'd32;
    localparam logic [FN_W-1:0] FN_SUB = 6'd34;
    localparam logic [FN_W-1:0] FN_AND = 6'd36;
    localparam logic [FN_W-1:0] FN_OR  = 6'd37;
    localparam logic [FN_W-1:0] FN_XOR = 6'd38;
    localparam logic [FN_W-1:0] FN_NOR = 6'd39;
    localparam logic [FN_W-1:0] FN_SLT = 6'd42;

    typedef enum logic [3:0] {
        OP_NONE, OP_ADD, OP_SUB, OP_AND, OP_OR,
        OP_XOR, OP_NOR, OP_SLT, OP_PASS_B
    } alu_op_e;

    typedef enum logic [1:0] {
        EXT_SIGN, EXT_ZERO, EXT_UPPER
    } ext_mode_e;
endpackage

// File: rtl/alu_ex_decode.sv
module alu_ex_decode
    import alu_ex_pkg::*;
(
    input  logic [OPC_W-1:0] op_code,
    input  logic [FN_W-1:0]  func_code,
    output alu_op_e          alu_op,
    output logic             use_imm,
    output ext_mode_e        ext_mode
);
    always_comb begin
        alu_op   = OP_NONE;
        use_imm  = 1'b0;
        ext_mode = EXT_ZERO;
        unique case (op_code)
            OPC_REG: begin
                unique case (func_code)
                    FN_ADD:  alu_op = OP_ADD;
                    FN_SUB:  alu_op = OP_SUB;
                    FN_AND:  alu_op = OP_AND;
                    FN_OR:   alu_op = OP_OR;
                    FN_XOR:  alu_op = OP_XOR;
                    FN_NOR:  alu_op = OP_NOR;
                    FN_SLT:  alu_op = OP_SLT;
                    default: alu_op = OP_NONE;
                endcase
            end
            OPC_ADDI: begin alu_op = OP_ADD;    use_imm = 1'b1; ext_mode = EXT_SIGN;  end
            OPC_ANDI: begin alu_op = OP_AND;    use_imm = 1'b1; ext_mode = EXT_ZERO;  end
            OPC_ORI:  begin alu_op = OP_OR;     use_imm = 1'b1; ext_mode = EXT_ZERO;  end
            OPC_XORI: begin alu_op = OP_XOR;    use_imm = 1'b1; ext_mode = EXT_ZERO;  end
            OPC_LUI:  begin alu_op = OP_PASS_B; use_imm = 1'b1; ext_mode = EXT_UPPER; end
            default:  alu_op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/alu_ex_immext.sv
module alu_ex_immext
    import alu_ex_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [IMM_W-1:0]  imm,
    input  ext_mode_e         ext_mode,
    output logic [DATA_W-1:0] imm_wide
);
    localparam int PAD_W = DATA_W - IMM_W;

    always_comb begin
        unique case (ext_mode)
            EXT_SIGN:  imm_wide = {{PAD_W{imm[IMM_W-1]}}, imm};
            EXT_UPPER: imm_wide = {imm, {PAD_W{1'b0}}};
            default:   imm_wide = {{PAD_W{1'b0}}, imm};
        endcase
    end
endmodule

// File: rtl/alu_ex_core.sv
module alu_ex_core
    import alu_ex_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  alu_op_e           alu_op,
    output logic [DATA_W-1:0] y
);
    logic lt_signed;
    assign lt_signed = $signed(opa) < $signed(opb);

    always_comb begin
        unique case (alu_op)
            OP_ADD:    y = opa + opb;
            OP_SUB:    y = opa - opb;
            OP_AND:    y = opa & opb;
            OP_OR:     y = opa | opb;
            OP_XOR:    y = opa ^ opb;
            OP_NOR:    y = ~(opa | opb);
            OP_SLT:    y = {{(DATA_W-1){1'b0}}, lt_signed};
            OP_PASS_B: y = opb;
            default:   y = '0;
        endcase
    end
endmodule

// File: rtl/alu_execute.sv
module alu_execute
    import alu_ex_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [OPC_W-1:0]  op_code,
    input  logic [FN_W-1:0]   func_code,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] result
);
    localparam int PAD_W = DATA_W - IMM_W;

    alu_op_e           alu_op;
    logic              use_imm;
    ext_mode_e         ext_mode;
    logic [DATA_W-1:0] imm_wide;
    logic [DATA_W-1:0] opb;

    alu_ex_decode u_dec (
        .op_code   (op_code),
        .func_code (func_code),
        .alu_op    (alu_op),
        .use_imm   (use_imm),
        .ext_mode  (ext_mode)
    );

    alu_ex_immext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
        .imm      (imm),
        .ext_mode (ext_mode),
        .imm_wide (imm_wide)
    );

    assign opb = use_imm ? imm_wide : rt_val;

    alu_ex_core #(.DATA_W(DATA_W)) u_core (
        .opa    (rs_val),
        .opb    (opb),
        .alu_op (alu_op),
        .y      (result)
    );

    always_comb begin
        if (op_code == OPC_LUI)
            AST_LUI_LOW_ZERO: assert (result[PAD_W-1:0] == '0 && result[DATA_W-1:PAD_W] == imm); // R8
        if (op_code == OPC_REG && func_code == FN_SLT)
            AST_SLT_IS_BIT: assert (result[DATA_W-1:1] == '0); // R5
        if (op_code == OPC_ANDI || op_code == OPC_ORI || op_code == OPC_XORI)
            AST_LOGIC_ZEXT: assert (opb[DATA_W-1:IMM_W] == '0); // R7
        if (op_code == OPC_ADDI)
            AST_ARITH_SEXT: assert (opb[DATA_W-1:IMM_W] == {PAD_W{imm[IMM_W-1]}}); // R6
        if (op_code == OPC_REG && func_code == FN_NOR && rs_val == '0 && rt_val == '0)
            AST_NOR_ZERO_ONES: assert (&result); // R4
        if (alu_op == OP_NONE)
            AST_UNSUPPORTED_ZERO: assert (result == '0); // R10
    end
endmodule

// File: tb/alu_execute_tb_top.sv
module alu_execute_tb_top;
    localparam int DW = 32;
    localparam int IW = 16;

    typedef struct {
        logic [DW-1:0] exp;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    op_code = '0;
    logic [5:0]    func_code = '0;
    logic [DW-1:0] rs_val = '0;
    logic [DW-1:0] rt_val = '0;
    logic [IW-1:0] imm = '0;
    logic [DW-1:0] result;

    item_t sb_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    bit    done     = 1'b0;

    always #2 clk = ~clk;

    alu_execute #(.DATA_W(DW), .IMM_W(IW)) dut_i (
        .op_code   (op_code),
        .func_code (func_code),
        .rs_val    (rs_val),
        .rt_val    (rt_val),
        .imm       (imm),
        .result    (result)
    );

    task automatic drive(input logic [5:0] op, input logic [5:0] fn,
                         input logic [DW-1:0] a, input logic [DW-1:0] b,
                         input logic [IW-1:0] im, input logic [DW-1:0] exp,
                         input string tag);
        item_t it;
        @(negedge clk);
        op_code = op; func_code = fn; rs_val = a; rt_val = b; imm = im;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (result !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, result, it.exp);
            end
        end
    end

    initial begin
        wait (cycles > 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset state: all-zero inputs decode to opcode 0/function 0 -> zero (R10)
        drive(6'd0, 6'd0, '0, '0, '0, 32'h0, "R10 reset-state zero");
        // R1 add with wrap
        drive(6'd0, 6'd32, 32'd5, 32'd7, 16'hFFFF, 32'd12, "R1 add small");
        drive(6'd0, 6'd32, 32'hFFFF_FFFF, 32'd2, 16'h0, 32'd1, "R1 add wrap");
        // R2 sub with wrap
        drive(6'd0, 6'd34, 32'd10, 32'd3, 16'h0, 32'd7, "R2 sub");
        drive(6'd0, 6'd34, 32'd0, 32'd1, 16'h0, 32'hFFFF_FFFF, "R2 sub wrap");
        // R3 logical register forms
        drive(6'd0, 6'd36, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 32'h00F0_1200, "R3 and");
        drive(6'd0, 6'd37, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 32'hFFF0_FF34, "R3 or");
        drive(6'd0, 6'd38, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 32'hFF00_ED34, "R3 xor");
        // R4 nor
        drive(6'd0, 6'd39, 32'h0, 32'h0, 16'h0, 32'hFFFF_FFFF, "R4 nor zeros");
        drive(6'd0, 6'd39, 32'hFF00_0000, 32'h0000_00FF, 16'h0, 32'h00FF_FF00, "R4 nor mixed");
        // R5 signed compare
        drive(6'd0, 6'd42, 32'hFFFF_FFFF, 32'd1, 16'h0, 32'd1, "R5 slt neg<pos");
        drive(6'd0, 6'd42, 32'd1, 32'h8000_0000, 16'h0, 32'd0, "R5 slt pos>min");
        drive(6'd0, 6'd42, 32'd9, 32'd9, 16'h0, 32'd0, "R5 slt equal");
        // R6 addi sign extension
        drive(6'd8, 6'd0, 32'd100, 32'h0, 16'hFFFF, 32'd99, "R6 addi -1");
        drive(6'd8, 6'd0, 32'd0, 32'h0, 16'h8000, 32'hFFFF_8000, "R6 addi min");
        drive(6'd8, 6'd0, 32'd1, 32'h0, 16'h7FFF, 32'h0000_8000, "R6 addi max");
        // R7 logical immediates zero-extended
        drive(6'd12, 6'd0, 32'hFFFF_FFFF, 32'h0, 16'h8001, 32'h0000_8001, "R7 andi");
        drive(6'd13, 6'd0, 32'h1234_0000, 32'h0, 16'hF00D, 32'h1234_F00D, "R7 ori");
        drive(6'd14, 6'd0, 32'hAAAA_AAAA, 32'h0, 16'hFFFF, 32'hAAAA_5555, "R7 xori");
        // R8 lui
        drive(6'd15, 6'd0, 32'hDEAD_BEEF, 32'h1234_5678, 16'h2110, 32'h2110_0000, "R8 lui");
        drive(6'd15, 6'd0, 32'h0, 32'h0, 16'hFFFF, 32'hFFFF_0000, "R8 lui ones");
        // R9 ignored operands
        drive(6'd13, 6'd0, 32'h0000_0001, 32'hFFFF_FFFF, 16'h0010, 32'h0000_0011, "R9 ori ignores rt");
        drive(6'd8, 6'd7, 32'd5, 32'hFFFF_FFFF, 16'd3, 32'd8, "R9 addi ignores rt/func");
        drive(6'd0, 6'd32, 32'd5, 32'd6, 16'hFFFF, 32'd11, "R9 add ignores imm");
        // R10 unsupported encodings
        drive(6'd0, 6'd33, 32'd5, 32'd6, 16'h1, 32'h0, "R10 unlisted func");
        drive(6'd9, 6'd32, 32'd5, 32'd6, 16'h1, 32'h0, "R10 unlisted opcode");
        drive(6'd63, 6'd42, 32'hFFFF_FFFF, 32'd6, 16'hFFFF, 32'h0, "R10 opcode 63");
        @(negedge clk);
        wait (sb_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule